// File: doc/BRIEF.md
# Writable-Store Microcode Sequencer

This block is the control unit of a small processor. It steps through microroutines held in a rewritable on-chip store of 256 words, 18 bits each. Every word carries a 2-bit next-address selector and 16 control lines. The control lines leave the block unchanged and drive the datapath directly, with no decoder in between.

Routine selection works by dispatch on the instruction opcode. One control line marks a step that waits on memory, and the sequencer holds that step until memory reports ready. While the halt input is high the sequencer is frozen, all control lines are low, and the store can be rewritten through a small load port. This changes the sequencing behaviour at run time without rebuilding the hardware.

The store read is synchronous. The sequencer presents the address it has just chosen, so the word for each step is in place one clock after the step is selected. A step that does not wait on memory therefore takes exactly one cycle.

Top module: `useq_ctrl`

## Requirements
- R1: While reset is high, and in the cycles after it until the sequencer first runs, `uaddr_o` is 0 and `ctrl_o` is 0.
- R2: A high `halt` forces `ctrl_o` to 0 from the next cycle on and freezes `uaddr_o`. After `halt` falls there is one more cycle with `ctrl_o` at 0, and then the word at the held address is presented.
- R3: While running, `ctrl_o` equals bits 15:0 of the store word at `uaddr_o`. Bit 15 is the memory-wait line, and bits 17:16 hold the next-address selector.
- R4: Selector 00, and the spare code 11, move to `uaddr_o + 1`, wrapping from 255 to 0.
- R5: Selector 01 dispatches to address 128 + 4 × `opcode`, using the opcode present in that cycle.
- R6: Selector 10 returns to address 0, the fetch routine entry.
- R7: A step with bit 15 set and `mem_ready` low holds `uaddr_o` and `ctrl_o`. It advances in the first cycle `mem_ready` is high. A step with bit 15 clear advances whatever the value of `mem_ready`.
- R8: A write on the load port (`ld_we` high) while `halt` is high replaces the store word at `ld_addr`. The new word is what runs when that address is next executed.
- R9: A load-port write while `halt` is low has no effect on the store.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| halt | input | 1 | Freezes sequencing and opens the load port |
| mem_ready | input | 1 | Memory access complete |
| opcode | input | 5 | Instruction opcode for dispatch |
| ld_we | input | 1 | Load-port write strobe |
| ld_addr | input | 8 | Load-port store address |
| ld_data | input | 18 | Load-port store word |
| uaddr_o | output | 8 | Current microaddress |
| ctrl_o | output | 16 | Control lines of the current step |

## Verification
Two functions can meet in one cycle: a memory stall and a halt. The bench raises `halt` while a memory-wait step is held with `mem_ready` low. It expects the controls to drop at the next cycle and the address to stay put. After release it expects the bubble cycle and then a replay of that same waiting step, not a skip past it. A load-port write in the same run while `halt` is low is judged by executing the targeted routine afterwards and comparing its control word with the original.

// File: rtl/useq_pkg.sv
package useq_pkg;

    // Next-address selector held in the two top bits of each store word.
    typedef enum logic [1:0] {
        NX_STEP  = 2'b00,
        NX_DISP  = 2'b01,
        NX_FETCH = 2'b10,
        NX_SPARE = 2'b11
    } nxt_sel_e;

endpackage

// File: rtl/useq_store.sv
// Writable control store with a registered (synchronous) read port.
module useq_store #(
    parameter int AW = 8,
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if (rd_en) begin
            rd_q <= mem[rd_addr];
        end
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/useq_next.sv
// Next-microaddress selection from the selector field of the current word.
module useq_next
    import useq_pkg::*;
#(
    parameter int AW    = 8,
    parameter int OPC_W = 5
) (
    input  nxt_sel_e         sel,
    input  logic [AW-1:0]    cur,
    input  logic [OPC_W-1:0] opcode,
    output logic [AW-1:0]    nxt
);
    localparam int SLOT_W = AW - 1 - OPC_W;

    logic [AW-1:0] entry;

    generate
        if (SLOT_W > 0) begin : g_slots
            assign entry = {1'b1, opcode, {SLOT_W{1'b0}}};
        end else begin : g_noslots
            assign entry = {1'b1, opcode};
        end
    endgenerate

    always_comb begin
        unique case (sel)
            NX_DISP:  nxt = entry;
            NX_FETCH: nxt = '0;
            default:  nxt = cur + 1'b1;
        endcase
    end
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
    import useq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int WORD_W = 18,
    parameter int OPC_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              halt,
    input  logic              mem_ready,
    input  logic [OPC_W-1:0]  opcode,
    input  logic              ld_we,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [WORD_W-1:0] ld_data,
    output logic [ADDR_W-1:0] uaddr_o,
    output logic [WORD_W-3:0] ctrl_o
);
    localparam int CTRL_W   = WORD_W - 2;
    localparam int MWAIT_IX = CTRL_W - 1;

    typedef struct packed {
        logic [ADDR_W-1:0] uaddr;
        logic              run;
    } seq_t;

    seq_t              st_d, st_q;
    logic [WORD_W-1:0] word;
    nxt_sel_e          sel;
    logic [ADDR_W-1:0] nxt_addr;
    logic              rd_en;
    logic [ADDR_W-1:0] rd_addr;
    logic              wr_en;
    logic              stall;
    logic              active;
    logic [1:0]        sel_bits;

    assign wr_en = ld_we & halt;

    useq_store #(.AW(ADDR_W), .DW(WORD_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (ld_addr),
        .wr_data (ld_data),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (word)
    );

    assign sel = nxt_sel_e'(word[WORD_W-1 -: 2]);

    useq_next #(.AW(ADDR_W), .OPC_W(OPC_W)) u_next (
        .sel    (sel),
        .cur    (st_q.uaddr),
        .opcode (opcode),
        .nxt    (nxt_addr)
    );

    always_comb begin
        st_d    = st_q;
        rd_en   = 1'b0;
        rd_addr = st_q.uaddr;
        stall   = st_q.run & word[MWAIT_IX] & ~mem_ready;
        if (halt) begin
            st_d.run = 1'b0;
        end else if (!st_q.run) begin
            st_d.run = 1'b1;
            rd_en    = 1'b1;
        end else if (!stall) begin
            st_d.uaddr = nxt_addr;
            rd_en      = 1'b1;
            rd_addr    = nxt_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active   = st_q.run;
    assign sel_bits = word[WORD_W-1 -: 2];
    assign uaddr_o  = st_q.uaddr;
    assign ctrl_o   = st_q.run ? word[CTRL_W-1:0] : '0;
endmodule

// File: rtl/useq_ctrl_chk.sv
module useq_ctrl_chk #(
    parameter int ADDR_W = 8,
    parameter int WORD_W = 18,
    parameter int OPC_W  = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              halt,
    input logic              mem_ready,
    input logic [OPC_W-1:0]  opcode,
    input logic              active,
    input logic [1:0]        sel_bits,
    input logic [ADDR_W-1:0] uaddr_o,
    input logic [WORD_W-3:0] ctrl_o
);
    localparam int SLOT_W = ADDR_W - 1 - OPC_W;

    logic              waiting;
    logic              moving;
    logic [ADDR_W-1:0] entry_exp;

    assign waiting   = active & ctrl_o[WORD_W-3] & ~mem_ready;
    assign moving    = active & ~halt & ~waiting;
    assign entry_exp = ADDR_W'((1 << (ADDR_W - 1)) + (int'(opcode) << SLOT_W));

    // R2
    halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        halt |=> (ctrl_o == '0) && $stable(uaddr_o));

    // R2
    resume_bubble_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(halt) |-> (ctrl_o == '0));

    // R7
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (waiting && !halt) |=> $stable(uaddr_o) && $stable(ctrl_o));

    // R4
    step_chk: assert property (@(posedge clk) disable iff (rst)
        (moving && sel_bits[1] == sel_bits[0]) |=> uaddr_o == $past(uaddr_o) + 1'b1);

    // R5
    dispatch_chk: assert property (@(posedge clk) disable iff (rst)
        (moving && sel_bits == 2'b01) |=> uaddr_o == $past(entry_exp));

    // R6
    fetch_return_chk: assert property (@(posedge clk) disable iff (rst)
        (moving && sel_bits == 2'b10) |=> uaddr_o == '0);
endmodule

bind useq_ctrl useq_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W),
    .OPC_W  (OPC_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .halt      (halt),
    .mem_ready (mem_ready),
    .opcode    (opcode),
    .active    (active),
    .sel_bits  (sel_bits),
    .uaddr_o   (uaddr_o),
    .ctrl_o    (ctrl_o)
);

// File: tb/useq_ctrl_test.sv
module useq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        halt = 1'b1;
    logic        mem_ready = 1'b0;
    logic [4:0]  opcode = '0;
    logic        ld_we = 1'b0;
    logic [7:0]  ld_addr = '0;
    logic [17:0] ld_data = '0;
    logic [7:0]  uaddr_o;
    logic [15:0] ctrl_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0]  ea;
        logic [15:0] ec;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    always #4 clk = ~clk;

    useq_ctrl uut (
        .clk       (clk),
        .rst       (rst),
        .halt      (halt),
        .mem_ready (mem_ready),
        .opcode    (opcode),
        .ld_we     (ld_we),
        .ld_addr   (ld_addr),
        .ld_data   (ld_data),
        .uaddr_o   (uaddr_o),
        .ctrl_o    (ctrl_o)
    );

    // Driver: sets inputs for this cycle and queues the outputs expected in it.
    task automatic step(input logic h, input logic r, input logic [4:0] opc,
                        input logic we, input logic [7:0] la, input logic [17:0] ld,
                        input logic [7:0] ea, input logic [15:0] ec, input string tag);
        exp_t it;
        @(posedge clk);
        #1;
        halt      = h;
        mem_ready = r;
        opcode    = opc;
        ld_we     = we;
        ld_addr   = la;
        ld_data   = ld;
        it.ea  = ea;
        it.ec  = ec;
        it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic run(input logic h, input logic r, input logic [4:0] opc,
                       input logic [7:0] ea, input logic [15:0] ec, input string tag);
        step(h, r, opc, 1'b0, 8'd0, 18'd0, ea, ec, tag);
    endtask

    task automatic load(input logic [7:0] a, input logic [17:0] d);
        step(1'b1, 1'b0, 5'd0, 1'b1, a, d, 8'd0, 16'h0000, "R1 halted during load");
    endtask

    // Monitor: compares away from the active edge.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t it;
            it = exp_q.pop_front();
            checks++;
            if (uaddr_o !== it.ea || ctrl_o !== it.ec) begin
                errors++;
                $display("FAIL %s: got uaddr=%0d ctrl=%h, expected uaddr=%0d ctrl=%h",
                         it.tag, uaddr_o, ctrl_o, it.ea, it.ec);
            end
        end
    end

    initial begin
        #1600000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        #1;
        checks++;
        if (uaddr_o !== 8'd0 || ctrl_o !== 16'h0000) begin
            errors++;
            $display("FAIL R1 in reset: got uaddr=%0d ctrl=%h, expected 0 0000", uaddr_o, ctrl_o);
        end
        rst = 1'b0;
        // Program: {sel[1:0], ctrl[15:0]}; ctrl bit 15 marks a memory wait.
        load(8'd0,   18'h08001);
        load(8'd1,   18'h10002);
        load(8'd140, 18'h20010);
        load(8'd148, 18'h00020);
        load(8'd149, 18'h28040);
        load(8'd252, 18'h00100);
        load(8'd253, 18'h30200);
        load(8'd254, 18'h00400);
        load(8'd255, 18'h00800);

        run(1'b0, 1'b0, 5'd0,  8'd0,   16'h0000, "R2 release bubble");
        run(1'b0, 1'b1, 5'd0,  8'd0,   16'h8001, "R3 fetch word at 0");
        run(1'b0, 1'b0, 5'd3,  8'd1,   16'h0002, "R7 non-memory step ignores ready");
        run(1'b0, 1'b0, 5'd0,  8'd140, 16'h0010, "R5 dispatch opcode 3");
        run(1'b0, 1'b0, 5'd0,  8'd0,   16'h8001, "R6 return to fetch");
        step(1'b0, 1'b0, 5'd0, 1'b1, 8'd148, 18'h00FFF, 8'd0, 16'h8001, "R7 stall held");
        run(1'b0, 1'b1, 5'd0,  8'd0,   16'h8001, "R7 stall still held");
        run(1'b0, 1'b0, 5'd5,  8'd1,   16'h0002, "R7 advance on ready");
        run(1'b0, 1'b0, 5'd0,  8'd148, 16'h0020, "R9 write while running ignored");
        run(1'b0, 1'b0, 5'd0,  8'd149, 16'h8040, "R4 sequential step");
        run(1'b1, 1'b0, 5'd0,  8'd149, 16'h8040, "R7 stall before halt");
        step(1'b1, 1'b0, 5'd0, 1'b1, 8'd140, 18'h20077, 8'd149, 16'h0000, "R2 halted over stall");
        run(1'b0, 1'b0, 5'd0,  8'd149, 16'h0000, "R2 bubble after halt");
        run(1'b0, 1'b1, 5'd0,  8'd149, 16'h8040, "R2 replay held step");
        run(1'b0, 1'b1, 5'd0,  8'd0,   16'h8001, "R6 return after replay");
        run(1'b0, 1'b0, 5'd3,  8'd1,   16'h0002, "R3 dispatch word");
        run(1'b0, 1'b0, 5'd0,  8'd140, 16'h0077, "R8 rewritten word runs");
        run(1'b0, 1'b1, 5'd0,  8'd0,   16'h8001, "R6 return to fetch");
        run(1'b0, 1'b0, 5'd31, 8'd1,   16'h0002, "R3 dispatch word");
        run(1'b0, 1'b0, 5'd0,  8'd252, 16'h0100, "R5 dispatch opcode 31");
        run(1'b0, 1'b0, 5'd0,  8'd253, 16'h0200, "R4 step");
        run(1'b0, 1'b0, 5'd0,  8'd254, 16'h0400, "R4 spare code steps");
        run(1'b0, 1'b0, 5'd0,  8'd255, 16'h0800, "R4 step");
        run(1'b0, 1'b0, 5'd0,  8'd0,   16'h8001, "R4 wrap to 0");
        run(1'b0, 1'b1, 5'd0,  8'd0,   16'h8001, "R7 stall at wrap");
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule